// File: doc/BRIEF.md
# Flash Program-Pulse Timing Sequencer

This block generates the control-bit timeline for a single flash programming pulse. It accepts a one-cycle start strobe while idle. It then walks through a fixed series of phases. First it turns on a watchdog-enable output and raises a program-setup bit. After a setup wait it raises the program bit for a chosen pulse width and then lowers it. It holds the setup bit through a hold wait and then lowers it. It keeps the watchdog enabled through a release wait. Finally it drops the watchdog enable and pulses `done`.

The pulse width is chosen when the start strobe is accepted. The choice depends on the caller's iteration count and on a mode input for additional programming. Early iterations get a short pulse and later ones a long pulse. The additional-programming mode always gets a very short pulse. Pulse widths are given in microseconds and turned into cycles by a cycles-per-microsecond parameter. The setup, hold and release waits are cycle counts.

A surrounding program/verify loop drives the block. It raises the iteration count on each retry and reads `busy` and `done` to know when the pulse is finished.

Top module: `flash_pulse_sequencer`

## Requirements
- R1: After a synchronous reset, `wdtEnable`, `setupBit`, `progBit`, `busy` and `done` are all low and the block is idle.
- R2: A start strobe sampled while idle makes `wdtEnable`, `setupBit` and `busy` high in the next cycle. This setup phase lasts exactly SETUP_CYC cycles, with `progBit` low throughout.
- R3: In each sequence `progBit` is high for one contiguous run. It is high only while `setupBit` is high, and it is low before `setupBit` falls.
- R4: With `extraMode` low and an iteration count of at most SHORT_LAST (default 6; counts 0 through 6 qualify), the `progBit` run lasts SHORT_US*CYC_PER_US cycles.
- R5: With `extraMode` low and an iteration count above SHORT_LAST (for example 7 to 1000), the run lasts LONG_US*CYC_PER_US cycles.
- R6: With `extraMode` high, the run lasts EXTRA_US*CYC_PER_US cycles for any iteration count.
- R7: After `progBit` falls, `setupBit` stays high for exactly HOLD_CYC cycles and then falls. `wdtEnable` then stays high for exactly RELEASE_CYC further cycles, with `setupBit` low.
- R8: In the cycle right after the release wait, `done` is high for exactly one cycle and `wdtEnable` is low. `busy` is high from the cycle after the accepted strobe through the `done` cycle, and low in the cycle after that.
- R9: A start strobe sampled while `busy` is high has no effect. `iterCount` and `extraMode` are sampled only at an accepted start, so changes during a sequence do not alter its pulse width.
- R10: A synchronous reset during a sequence makes all outputs low in the next cycle and returns the block to idle. A later start then runs a complete, normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | One-cycle request to run a pulse sequence |
| iterCount | input | ITER_W | Current programming iteration number |
| extraMode | input | 1 | High selects the additional-programming pulse width |
| wdtEnable | output | 1 | Watchdog enable, high for the whole sequence except the done cycle |
| setupBit | output | 1 | Program-setup control bit |
| progBit | output | 1 | Program control bit (the pulse itself) |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A behavioural reference model predicts every output in every cycle and is compared each clock. The stimulus includes iteration counts 0, 1, 6, 7 and 1000 with the mode low. Counts 6 and 7 sit on either side of the short/long boundary, so an off-by-one in the threshold shows as a wrong pulse length. The mode is also tried high with both a low and a high count, which shows whether the mode overrides the count. Separate runs fire start strobes and change the count and mode in the middle of a sequence, and reset the block in the middle of a pulse. These show whether the width is latched at acceptance and whether the block recovers to a clean idle.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RELEASE,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_RELEASE
  } phase_t;

  typedef enum logic [1:0] {
    PW_SHORT,
    PW_LONG,
    PW_EXTRA
  } pulseKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;    // latch the pulse-width class
    logic   load;       // reload the wait counter
    phase_t loadPhase;  // which wait length to load
  } dpStrobe_t;

endpackage

// File: rtl/fps_pulse_select.sv
module fps_pulse_select
  import fps_pkg::*;
#(
  parameter int ITER_W     = 10,
  parameter int SHORT_LAST = 6
) (
  input  logic [ITER_W-1:0] iterCount,
  input  logic              extraMode,
  output pulseKind_t        kind
);

  localparam int ITER_LIMIT = (1 << ITER_W) - 1;

  logic isEarly;

  generate
    if (SHORT_LAST >= ITER_LIMIT) begin : g_all_early
      assign isEarly = 1'b1;
    end else begin : g_cmp
      localparam logic [ITER_W-1:0] LAST_EARLY = ITER_W'(SHORT_LAST);
      assign isEarly = (iterCount <= LAST_EARLY);
    end
  endgenerate

  always_comb begin
    if (extraMode)    kind = PW_EXTRA;
    else if (isEarly) kind = PW_SHORT;
    else              kind = PW_LONG;
  end

endmodule

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int ITER_W      = 10,
  parameter int SHORT_LAST  = 6,
  parameter int CYC_PER_US  = 50,
  parameter int SHORT_US    = 30,
  parameter int LONG_US     = 200,
  parameter int EXTRA_US    = 10,
  parameter int SETUP_CYC   = 250,
  parameter int HOLD_CYC    = 250,
  parameter int RELEASE_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ITER_W-1:0] iterCount,
  input  logic              extraMode,
  output logic              expired
);

  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG_CYC  = LONG_US  * CYC_PER_US;
  localparam int EXTRA_CYC = EXTRA_US * CYC_PER_US;
  localparam int MAX_A     = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int MAX_B     = (EXTRA_CYC > SETUP_CYC) ? EXTRA_CYC : SETUP_CYC;
  localparam int MAX_C     = (HOLD_CYC > RELEASE_CYC) ? HOLD_CYC : RELEASE_CYC;
  localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SHORT_LD   = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD    = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] EXTRA_LD   = CNT_W'(EXTRA_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RELEASE_LD = CNT_W'(RELEASE_CYC - 1);

  pulseKind_t       kindNow;
  pulseKind_t       kindHeld;
  logic [CNT_W-1:0] pulseLoad;
  logic [CNT_W-1:0] loadValue;
  logic [CNT_W-1:0] remaining;

  fps_pulse_select #(
    .ITER_W     (ITER_W),
    .SHORT_LAST (SHORT_LAST)
  ) u_select (
    .iterCount (iterCount),
    .extraMode (extraMode),
    .kind      (kindNow)
  );

  // width class is frozen at the accepted start
  always_ff @(posedge clk) begin
    if (rst)                 kindHeld <= PW_SHORT;
    else if (strobe.capture) kindHeld <= kindNow;
  end

  always_comb begin
    unique case (kindHeld)
      PW_LONG:  pulseLoad = LONG_LD;
      PW_EXTRA: pulseLoad = EXTRA_LD;
      default:  pulseLoad = SHORT_LD;
    endcase
  end

  always_comb begin
    unique case (strobe.loadPhase)
      PH_PULSE:   loadValue = pulseLoad;
      PH_HOLD:    loadValue = HOLD_LD;
      PH_RELEASE: loadValue = RELEASE_LD;
      default:    loadValue = SETUP_LD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   remaining <= '0;
    else if (strobe.load)      remaining <= loadValue;
    else if (remaining != '0)  remaining <= remaining - 1'b1;
  end

  assign expired = (remaining == '0);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startPulse,
  input  logic      expired,
  output dpStrobe_t strobe,
  output logic      wdtEnable,
  output logic      setupBit,
  output logic      progBit,
  output logic      busy,
  output logic      done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState        = state;
    strobe.capture   = 1'b0;
    strobe.load      = 1'b0;
    strobe.loadPhase = PH_SETUP;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        nextState      = ST_SETUP;
        strobe.capture = 1'b1;
        strobe.load    = 1'b1;
      end
      ST_SETUP: if (expired) begin
        nextState        = ST_PULSE;
        strobe.load      = 1'b1;
        strobe.loadPhase = PH_PULSE;
      end
      ST_PULSE: if (expired) begin
        nextState        = ST_HOLD;
        strobe.load      = 1'b1;
        strobe.loadPhase = PH_HOLD;
      end
      ST_HOLD: if (expired) begin
        nextState        = ST_RELEASE;
        strobe.load      = 1'b1;
        strobe.loadPhase = PH_RELEASE;
      end
      ST_RELEASE: if (expired) nextState = ST_DONE;
      ST_DONE:    nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    wdtEnable = (state == ST_SETUP) || (state == ST_PULSE) ||
                (state == ST_HOLD)  || (state == ST_RELEASE);
    setupBit  = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
    progBit   = (state == ST_PULSE);
    busy      = (state != ST_IDLE);
    done      = (state == ST_DONE);
  end

endmodule

// File: rtl/flash_pulse_sequencer.sv
module flash_pulse_sequencer
  import fps_pkg::*;
#(
  parameter int ITER_W      = 10,
  parameter int SHORT_LAST  = 6,
  parameter int CYC_PER_US  = 50,
  parameter int SHORT_US    = 30,
  parameter int LONG_US     = 200,
  parameter int EXTRA_US    = 10,
  parameter int SETUP_CYC   = 250,
  parameter int HOLD_CYC    = 250,
  parameter int RELEASE_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  input  logic [ITER_W-1:0] iterCount,
  input  logic              extraMode,
  output logic              wdtEnable,
  output logic              setupBit,
  output logic              progBit,
  output logic              busy,
  output logic              done
);

  dpStrobe_t strobe;
  logic      expired;

  fps_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .expired    (expired),
    .strobe     (strobe),
    .wdtEnable  (wdtEnable),
    .setupBit   (setupBit),
    .progBit    (progBit),
    .busy       (busy),
    .done       (done)
  );

  fps_datapath #(
    .ITER_W      (ITER_W),
    .SHORT_LAST  (SHORT_LAST),
    .CYC_PER_US  (CYC_PER_US),
    .SHORT_US    (SHORT_US),
    .LONG_US     (LONG_US),
    .EXTRA_US    (EXTRA_US),
    .SETUP_CYC   (SETUP_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .RELEASE_CYC (RELEASE_CYC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .iterCount (iterCount),
    .extraMode (extraMode),
    .expired   (expired)
  );

endmodule

// File: rtl/fps_seq_checker.sv
module fps_seq_checker (
  input logic clk,
  input logic rst,
  input logic startPulse,
  input logic wdtEnable,
  input logic setupBit,
  input logic progBit,
  input logic busy,
  input logic done
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!wdtEnable && !setupBit && !progBit && !busy && !done));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && startPulse) |=> (wdtEnable && setupBit && busy && !progBit));

  // R3
  prog_inside_setup_chk: assert property (@(posedge clk) disable iff (rst)
    progBit |-> (setupBit && wdtEnable));

  // R3
  setup_falls_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(setupBit)) |-> (!progBit && !$past(progBit)));

  // R7
  hold_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(progBit)) |-> (setupBit && wdtEnable));

  // R8
  done_shape_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && !wdtEnable && !setupBit && !progBit));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R9
  setup_rise_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(setupBit)) |-> (!$past(busy) && $past(startPulse)));

endmodule

bind flash_pulse_sequencer fps_seq_checker u_seq_chk (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .wdtEnable  (wdtEnable),
  .setupBit   (setupBit),
  .progBit    (progBit),
  .busy       (busy),
  .done       (done)
);

// File: tb/flash_pulse_sequencer_bench.sv
module flash_pulse_sequencer_bench;

  localparam int ITER_W = 10;
  localparam int CPU    = 1;
  localparam int S_CYC  = 3;
  localparam int H_CYC  = 2;
  localparam int R_CYC  = 4;
  localparam int SHORT_P = 30 * CPU;
  localparam int LONG_P  = 200 * CPU;
  localparam int EXTRA_P = 10 * CPU;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              startPulse = 1'b0;
  logic [ITER_W-1:0] iterCount = '0;
  logic              extraMode = 1'b0;
  logic              wdtEnable, setupBit, progBit, busy, done;

  always #10 clk = ~clk;

  flash_pulse_sequencer #(
    .ITER_W (ITER_W), .SHORT_LAST (6), .CYC_PER_US (CPU),
    .SHORT_US (30), .LONG_US (200), .EXTRA_US (10),
    .SETUP_CYC (S_CYC), .HOLD_CYC (H_CYC), .RELEASE_CYC (R_CYC)
  ) u_flash_pulse_sequencer (
    .clk (clk), .rst (rst), .startPulse (startPulse),
    .iterCount (iterCount), .extraMode (extraMode),
    .wdtEnable (wdtEnable), .setupBit (setupBit), .progBit (progBit),
    .busy (busy), .done (done)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  bit    chkOn = 0;
  string curReq = "R1";

  // reference model state
  bit mBusy = 0;
  int t = 0;
  int mP = SHORT_P;
  int total = 0;

  function automatic int pickWidth(int iter, bit ext);
    if (ext) return EXTRA_P;
    if (iter <= 6) return SHORT_P;
    return LONG_P;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) mBusy = 0;
    else if (mBusy) begin
      t = t + 1;
      if (t == total) mBusy = 0;
    end else if (startPulse) begin
      mBusy = 1;
      t = 0;
      mP = pickWidth(int'(iterCount), extraMode);
      total = S_CYC + mP + H_CYC + R_CYC + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chkOn) begin
      bit eW, eS, eP, eB, eD;
      {eW, eS, eP, eB, eD} = 5'b0;
      if (mBusy) begin
        eB = 1;
        if (t < S_CYC) begin eW = 1; eS = 1; end
        else if (t < S_CYC + mP) begin eW = 1; eS = 1; eP = 1; end
        else if (t < S_CYC + mP + H_CYC) begin eW = 1; eS = 1; end
        else if (t < S_CYC + mP + H_CYC + R_CYC) eW = 1;
        else eD = 1;
      end
      check({curReq, "/R7"}, "wdtEnable", int'(wdtEnable), int'(eW));
      check({curReq, "/R2"}, "setupBit",  int'(setupBit),  int'(eS));
      check({curReq, "/R3"}, "progBit",   int'(progBit),   int'(eP));
      check({curReq, "/R8"}, "busy",      int'(busy),      int'(eB));
      check({curReq, "/R8"}, "done",      int'(done),      int'(eD));
    end
  end

  // pulse length measured at the port
  int runLen = 0;
  int runCount = 0;
  int doneCount = 0;
  always @(negedge clk) begin
    if (rst) runLen = 0;
    else if (progBit) runLen++;
    else if (runLen > 0) begin
      check(curReq, "pulse length", runLen, mP);
      runCount++;
      runLen = 0;
    end
    if (done) doneCount++;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      summary();
    end
  end

  task automatic runSeq(int iter, bit ext, string req);
    int pulses0, dones0;
    curReq = req;
    @(negedge clk);
    pulses0 = runCount;
    dones0 = doneCount;
    iterCount = ITER_W'(iter);
    extraMode = ext;
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    while (busy) @(negedge clk);
    check(req, "pulses per sequence (R3)", runCount - pulses0, 1);
    check(req, "done pulses (R8)", doneCount - dones0, 1);
  endtask

  initial begin
    @(posedge clk);
    #1 chkOn = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "outputs after reset", int'({wdtEnable, setupBit, progBit, busy, done}), 0);
    rst = 0;
    @(negedge clk);
    check("R1", "idle stays quiet", int'({wdtEnable, setupBit, progBit, busy, done}), 0);

    runSeq(1, 0, "R4");      // R4 short pulse
    runSeq(6, 0, "R4");      // R4 boundary
    runSeq(0, 0, "R4");      // R4 zero count
    runSeq(7, 0, "R5");      // R5 boundary
    runSeq(1000, 0, "R5");   // R5 top
    runSeq(1, 1, "R6");      // R6 mode overrides low count
    runSeq(500, 1, "R6");    // R6 mode overrides high count

    // R9: strobes and input changes while busy
    curReq = "R9";
    @(negedge clk);
    iterCount = 10'd2; extraMode = 0; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    iterCount = 10'd900; extraMode = 1;
    for (int k = 0; k < 60; k++) begin
      startPulse = (k % 7 == 0);
      @(negedge clk);
    end
    startPulse = 0;
    while (busy) begin
      startPulse = done;   // strobe in the done cycle too
      @(negedge clk);
    end
    startPulse = 0;
    check("R9", "busy after ignored strobes", int'(busy), 0);

    // R10: reset in the middle of the pulse
    curReq = "R10";
    iterCount = 10'd8; extraMode = 0; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    repeat (S_CYC + 20) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R10", "outputs after mid reset", int'({wdtEnable, setupBit, progBit, busy, done}), 0);
    repeat (2) @(negedge clk);
    runSeq(3, 0, "R10");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule